// File: doc/BRIEF.md
# Single-Cycle Control Decoder for a 32-bit Load/Store Core

This block turns one fetched 32-bit instruction word into the full set of datapath steering signals that a single-cycle load/store processor needs. It does this in one cycle and holds no state. It splits out the three register index fields and sign-extends the 16-bit literal to 32 bits. It then classifies the opcode and drives the following controls:

- register-file write enable
- memory write strobe
- ALU function code
- A-operand, B-operand, second-read-address, write-address, write-data and next-PC select codes

A single input, the zero indication of the first source register, lets the decoder settle the conditional branch by itself.

The decoder sits between instruction memory and the datapath multiplexers. The register file, ALU, memories and PC register are outside it; they consume the select codes defined below. Store needs its data register read on the second port, so a dedicated select moves that port's address from the rb field to the rc field. Load-relative forms its address from the program counter, so a dedicated A-operand select routes the PC-relative address into the ALU, and the ALU passes that operand through. Any opcode outside the supported set raises an illegal flag and steers the next PC to the exception handler. That path keeps the return address in the exception register and never writes memory.

Top module: `rsc_ctl_decoder`

## Requirements
- R1: The register index outputs are taken from the instruction as follows: rc_idx from bits 25:21, ra_idx from bits 20:16, and rb_idx from bits 15:11. The opcode is bits 31:26.
- R2: lit_sext equals bits 15:0 of the instruction, sign-extended to 32 bits by replicating bit 15.
- R3: Opcode 6'b100000 (register add) and opcode 6'b110000 (literal add) both drive the following:
  - rf_we=1, mem_we=0, alu_fn=0 (add), wd_sel=1 (ALU result), pc_sel=0 (PC+4), wa_sel=0, a_sel=0, rd2_sel=0.
  - b_sel=0 (rb) for the register form and b_sel=1 (literal) for the literal form.
- R4: Load, opcode 6'b011000, drives rf_we=1, mem_we=0, alu_fn=0, b_sel=1, wd_sel=2 (memory read data) and pc_sel=0.
- R5: Store, opcode 6'b011001, drives mem_we=1, rf_we=0, rd2_sel=1 (second read address from rc), b_sel=1, alu_fn=0, wd_sel=1 and pc_sel=0.
- R6: Jump, opcode 6'b011011, drives rf_we=1, wd_sel=0 (PC+4 as link) and pc_sel=2 (register target). Memory is not written.
- R7: Branch-if-zero, opcode 6'b011101, drives rf_we=1 and wd_sel=0. It drives pc_sel=1 (branch target PC+4+literal*4) when ra_zero=1, and pc_sel=0 when ra_zero=0.
- R8: Load-relative, opcode 6'b011111, drives a_sel=1 (PC-relative address), alu_fn=1 (pass A), b_sel=0, rf_we=1, wd_sel=2 and pc_sel=0.
- R9: Every other opcode, including opcode 0, drives illegal=1, pc_sel=3 (exception handler), wa_sel=1 (exception register), wd_sel=0, rf_we=1, mem_we=0, a_sel=0, b_sel=0, rd2_sel=0 and alu_fn=0. For the seven opcodes above, illegal=0 and wa_sel=0.
- R10: mem_we and rd2_sel are 1 only for store, and a_sel is 1 only for load-relative. ra_zero has no effect on any output for any opcode except branch-if-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Fetched instruction word |
| ra_zero | input | 1 | High when the value read for ra is zero |
| rc_idx | output | 5 | Destination/store-data register index |
| ra_idx | output | 5 | First source register index |
| rb_idx | output | 5 | Second source register index |
| lit_sext | output | 32 | Sign-extended 16-bit literal |
| rf_we | output | 1 | Register-file write enable |
| mem_we | output | 1 | Data memory write strobe |
| alu_fn | output | 2 | ALU function: 0 add, 1 pass A |
| a_sel | output | 1 | ALU A source: 0 ra data, 1 PC-relative address |
| b_sel | output | 1 | ALU B source: 0 rb data, 1 literal |
| rd2_sel | output | 1 | Second read address: 0 rb, 1 rc |
| wa_sel | output | 1 | Write address: 0 rc, 1 exception register |
| wd_sel | output | 2 | Write data: 0 PC+4, 1 ALU result, 2 memory data |
| pc_sel | output | 3 | Next PC: 0 PC+4, 1 branch target, 2 register target, 3 exception handler |
| illegal | output | 1 | Unsupported opcode |

## Verification
Branch-if-zero is the one instruction on which two decisions coincide in a single cycle: it writes the link value and it chooses between sequential and branch targets. The bench drives it with ra_zero both low and high, using several literal and register patterns. On each clock it judges rf_we and wd_sel together with pc_sel against a behavioural reference. Every one of the 64 opcodes is also swept with both ra_zero values, to show that the zero flag never leaks into the next-PC choice of any other instruction, and that the illegal path and the memory strobe never coincide.

// File: rtl/rsc_ctl_pkg.sv
// Package: shared widths, field positions, opcode values and select codes
// for the single-cycle control decoder. Assumes a 32-bit word with the
// opcode at the top, followed by three 5-bit register fields.
package rsc_ctl_pkg;

    localparam int XLEN   = 32;
    localparam int OPW    = 6;
    localparam int RIDW   = 5;
    localparam int LITW   = 16;
    localparam int OP_LSB = XLEN - OPW;
    localparam int RC_LSB = OP_LSB - RIDW;
    localparam int RA_LSB = RC_LSB - RIDW;
    localparam int RB_LSB = RA_LSB - RIDW;
    localparam int BODYW  = OP_LSB;

    localparam logic [OPW-1:0] OP_ADD  = 6'b100000;
    localparam logic [OPW-1:0] OP_ADDC = 6'b110000;
    localparam logic [OPW-1:0] OP_LD   = 6'b011000;
    localparam logic [OPW-1:0] OP_ST   = 6'b011001;
    localparam logic [OPW-1:0] OP_JMP  = 6'b011011;
    localparam logic [OPW-1:0] OP_BEQ  = 6'b011101;
    localparam logic [OPW-1:0] OP_LDR  = 6'b011111;

    localparam logic [1:0] ALU_ADD   = 2'd0;
    localparam logic [1:0] ALU_PASSA = 2'd1;

    localparam logic [1:0] WD_PC4 = 2'd0;
    localparam logic [1:0] WD_ALU = 2'd1;
    localparam logic [1:0] WD_MEM = 2'd2;

    localparam logic [2:0] PC_SEQ = 3'd0;
    localparam logic [2:0] PC_BR  = 3'd1;
    localparam logic [2:0] PC_JR  = 3'd2;
    localparam logic [2:0] PC_ILL = 3'd3;

    typedef enum logic [2:0] {
        K_ADD, K_ADDC, K_LD, K_ST, K_JMP, K_BEQ, K_LDR, K_ILL
    } op_kind_e;

    typedef struct packed {
        logic       rf_we;
        logic       mem_we;
        logic [1:0] alu_fn;
        logic       a_sel;
        logic       b_sel;
        logic       rd2_sel;
        logic       wa_sel;
        logic [1:0] wd_sel;
        logic [2:0] pc_sel;
        logic       illegal;
    } ctl_t;

endpackage

// File: rtl/rsc_field_split.sv
// Module: splits the instruction body (everything below the opcode) into
// register indices and a sign-extended literal. Assumes the field layout
// from rsc_ctl_pkg. Purely combinational.
module rsc_field_split
    import rsc_ctl_pkg::*;
#(
    parameter int W_BODY = BODYW,
    parameter int W_RID  = RIDW,
    parameter int W_LIT  = LITW,
    parameter int W_OUT  = XLEN
) (
    input  logic [W_BODY-1:0] body,
    output logic [W_RID-1:0]  rc_idx,
    output logic [W_RID-1:0]  ra_idx,
    output logic [W_RID-1:0]  rb_idx,
    output logic [W_OUT-1:0]  lit_sext
);
    localparam int L_RC  = W_BODY - W_RID;
    localparam int L_RA  = L_RC - W_RID;
    localparam int L_RB  = L_RA - W_RID;
    localparam int W_EXT = W_OUT - W_LIT;

    // Purpose: slice the three register index fields.
    always_comb begin
        rc_idx = body[L_RC +: W_RID];
        ra_idx = body[L_RA +: W_RID];
        rb_idx = body[L_RB +: W_RID];
    end

    // Purpose: replicate the literal sign bit up to the full word width.
    always_comb begin
        lit_sext = {{W_EXT{body[W_LIT-1]}}, body[W_LIT-1:0]};
    end
endmodule

// File: rtl/rsc_op_classify.sv
// Module: maps a 6-bit opcode to an instruction kind. Any opcode that is
// not one of the seven supported values maps to K_ILL. Combinational.
module rsc_op_classify
    import rsc_ctl_pkg::*;
#(
    parameter int W_OP = OPW
) (
    input  logic [W_OP-1:0] opcode,
    output op_kind_e        kind
);
    // Purpose: exact opcode match, with illegal as the fallback.
    always_comb begin
        unique case (opcode)
            OP_ADD:  kind = K_ADD;
            OP_ADDC: kind = K_ADDC;
            OP_LD:   kind = K_LD;
            OP_ST:   kind = K_ST;
            OP_JMP:  kind = K_JMP;
            OP_BEQ:  kind = K_BEQ;
            OP_LDR:  kind = K_LDR;
            default: kind = K_ILL;
        endcase
    end
endmodule

// File: rtl/rsc_ctl_table.sv
// Module: produces the control word for one instruction kind. Every output
// has a defined value for every kind (no don't-cares), so downstream logic
// and checks see a stable encoding. ra_zero only matters for K_BEQ.
module rsc_ctl_table
    import rsc_ctl_pkg::*;
(
    input  op_kind_e kind,
    input  logic     ra_zero,
    output ctl_t     ctl
);
    // Purpose: start from a neutral word, then apply per-kind overrides.
    always_comb begin
        ctl         = '0;
        ctl.alu_fn  = ALU_ADD;
        ctl.wd_sel  = WD_ALU;
        ctl.pc_sel  = PC_SEQ;
        unique case (kind)
            K_ADD: begin
                ctl.rf_we = 1'b1;
            end
            K_ADDC: begin
                ctl.rf_we = 1'b1;
                ctl.b_sel = 1'b1;
            end
            K_LD: begin
                ctl.rf_we  = 1'b1;
                ctl.b_sel  = 1'b1;
                ctl.wd_sel = WD_MEM;
            end
            K_ST: begin
                ctl.mem_we  = 1'b1;
                ctl.b_sel   = 1'b1;
                ctl.rd2_sel = 1'b1;
            end
            K_JMP: begin
                ctl.rf_we  = 1'b1;
                ctl.wd_sel = WD_PC4;
                ctl.pc_sel = PC_JR;
            end
            K_BEQ: begin
                ctl.rf_we  = 1'b1;
                ctl.wd_sel = WD_PC4;
                ctl.pc_sel = ra_zero ? PC_BR : PC_SEQ;
            end
            K_LDR: begin
                ctl.rf_we  = 1'b1;
                ctl.a_sel  = 1'b1;
                ctl.alu_fn = ALU_PASSA;
                ctl.wd_sel = WD_MEM;
            end
            default: begin
                ctl.rf_we   = 1'b1;
                ctl.wa_sel  = 1'b1;
                ctl.wd_sel  = WD_PC4;
                ctl.pc_sel  = PC_ILL;
                ctl.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rsc_ctl_decoder.sv
// Module: top of the single-cycle control decoder. It joins the field
// splitter, the opcode classifier and the control table, and spreads the
// control word onto plain ports. Holds no state and takes no clock; all
// outputs follow instr and ra_zero within the same cycle.
module rsc_ctl_decoder
    import rsc_ctl_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  logic            ra_zero,
    output logic [RIDW-1:0] rc_idx,
    output logic [RIDW-1:0] ra_idx,
    output logic [RIDW-1:0] rb_idx,
    output logic [XLEN-1:0] lit_sext,
    output logic            rf_we,
    output logic            mem_we,
    output logic [1:0]      alu_fn,
    output logic            a_sel,
    output logic            b_sel,
    output logic            rd2_sel,
    output logic            wa_sel,
    output logic [1:0]      wd_sel,
    output logic [2:0]      pc_sel,
    output logic            illegal
);
    op_kind_e kind;
    ctl_t     ctl;

    rsc_field_split u_fields (
        .body     (instr[BODYW-1:0]),
        .rc_idx   (rc_idx),
        .ra_idx   (ra_idx),
        .rb_idx   (rb_idx),
        .lit_sext (lit_sext)
    );

    rsc_op_classify u_class (
        .opcode (instr[OP_LSB +: OPW]),
        .kind   (kind)
    );

    rsc_ctl_table u_table (
        .kind    (kind),
        .ra_zero (ra_zero),
        .ctl     (ctl)
    );

    // Purpose: unpack the control word onto the output ports.
    always_comb begin
        rf_we   = ctl.rf_we;
        mem_we  = ctl.mem_we;
        alu_fn  = ctl.alu_fn;
        a_sel   = ctl.a_sel;
        b_sel   = ctl.b_sel;
        rd2_sel = ctl.rd2_sel;
        wa_sel  = ctl.wa_sel;
        wd_sel  = ctl.wd_sel;
        pc_sel  = ctl.pc_sel;
        illegal = ctl.illegal;
    end
endmodule

// File: rtl/rsc_ctl_checker.sv
// Module: assertion checker for rsc_ctl_decoder. The decoder is
// combinational, so the checks are immediate assertions re-evaluated
// whenever the ports change. They relate the opcode at the port to the
// control outputs produced by the separate classifier and table.
module rsc_ctl_checker
    import rsc_ctl_pkg::*;
(
    input logic [XLEN-1:0] instr,
    input logic            ra_zero,
    input logic            rf_we,
    input logic            mem_we,
    input logic [1:0]      alu_fn,
    input logic            a_sel,
    input logic            b_sel,
    input logic            rd2_sel,
    input logic            wa_sel,
    input logic [1:0]      wd_sel,
    input logic [2:0]      pc_sel,
    input logic            illegal
);
    logic [OPW-1:0] op;
    assign op = instr[OP_LSB +: OPW];

    // Purpose: cross-check the outputs against the opcode on every change.
    always_comb begin
        p_store_strobe_r5: assert (!mem_we || (op == OP_ST && !rf_we && rd2_sel && b_sel));
        p_exc_path_r9:     assert (!illegal || (pc_sel == PC_ILL && wa_sel && rf_we && !mem_we && wd_sel == WD_PC4));
        p_branch_cond_r7:  assert (pc_sel != PC_BR || (op == OP_BEQ && ra_zero));
        p_ldr_asel_r8:     assert (!a_sel || (op == OP_LDR && alu_fn == ALU_PASSA && wd_sel == WD_MEM));
        p_rd2_only_st_r10: assert (!rd2_sel || op == OP_ST);
        p_jump_link_r6:    assert (pc_sel != PC_JR || (op == OP_JMP && wd_sel == WD_PC4 && rf_we));
    end
endmodule

bind rsc_ctl_decoder rsc_ctl_checker u_chk (
    .instr   (instr),
    .ra_zero (ra_zero),
    .rf_we   (rf_we),
    .mem_we  (mem_we),
    .alu_fn  (alu_fn),
    .a_sel   (a_sel),
    .b_sel   (b_sel),
    .rd2_sel (rd2_sel),
    .wa_sel  (wa_sel),
    .wd_sel  (wd_sel),
    .pc_sel  (pc_sel),
    .illegal (illegal)
);

// File: tb/tb_rsc_ctl_decoder.sv
// Bench: drives instruction words on the rising edge and compares every
// output against a behavioural reference model on each falling edge.
module tb_rsc_ctl_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic        ra_zero;

    logic [4:0]  rc_idx, ra_idx, rb_idx;
    logic [31:0] lit_sext;
    logic        rf_we, mem_we, a_sel, b_sel, rd2_sel, wa_sel, illegal;
    logic [1:0]  alu_fn, wd_sel;
    logic [2:0]  pc_sel;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    rsc_ctl_decoder dut (
        .instr(instr), .ra_zero(ra_zero),
        .rc_idx(rc_idx), .ra_idx(ra_idx), .rb_idx(rb_idx), .lit_sext(lit_sext),
        .rf_we(rf_we), .mem_we(mem_we), .alu_fn(alu_fn), .a_sel(a_sel),
        .b_sel(b_sel), .rd2_sel(rd2_sel), .wa_sel(wa_sel), .wd_sel(wd_sel),
        .pc_sel(pc_sel), .illegal(illegal)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: instr=%08h z=%0d actual=%0d expected=%0d",
                     req, what, instr, ra_zero, act, exp);
        end
    endtask

    // Reference model expressed as integers per instruction meaning.
    int e_we, e_mw, e_alu, e_as, e_bs, e_r2, e_wa, e_wd, e_pc, e_il;
    string e_tag;

    task automatic model(input logic [31:0] w, input logic z);
        int op;
        op = int'(w[31:26]);
        e_we = 1; e_mw = 0; e_alu = 0; e_as = 0; e_bs = 0;
        e_r2 = 0; e_wa = 0; e_wd = 1; e_pc = 0; e_il = 0;
        if (op == 'h20)      begin e_tag = "R3"; end
        else if (op == 'h30) begin e_tag = "R3"; e_bs = 1; end
        else if (op == 'h18) begin e_tag = "R4"; e_bs = 1; e_wd = 2; end
        else if (op == 'h19) begin e_tag = "R5"; e_we = 0; e_mw = 1; e_bs = 1; e_r2 = 1; end
        else if (op == 'h1B) begin e_tag = "R6"; e_wd = 0; e_pc = 2; end
        else if (op == 'h1D) begin e_tag = "R7"; e_wd = 0; e_pc = z ? 1 : 0; end
        else if (op == 'h1F) begin e_tag = "R8"; e_as = 1; e_alu = 1; e_wd = 2; end
        else begin e_tag = "R9"; e_wa = 1; e_wd = 0; e_pc = 3; e_il = 1; end
    endtask

    // Compare all outputs against the model every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            model(instr, ra_zero);
            chk("R1", "rc_idx", int'(rc_idx), int'(instr[25:21]));
            chk("R1", "ra_idx", int'(ra_idx), int'(instr[20:16]));
            chk("R1", "rb_idx", int'(rb_idx), int'(instr[15:11]));
            chk("R2", "lit_sext", int'(lit_sext), int'($signed(instr[15:0])));
            chk(e_tag, "rf_we",   int'(rf_we),   e_we);
            chk(e_tag, "mem_we",  int'(mem_we),  e_mw);
            chk(e_tag, "alu_fn",  int'(alu_fn),  e_alu);
            chk(e_tag, "a_sel",   int'(a_sel),   e_as);
            chk(e_tag, "b_sel",   int'(b_sel),   e_bs);
            chk(e_tag, "rd2_sel", int'(rd2_sel), e_r2);
            chk(e_tag, "wa_sel",  int'(wa_sel),  e_wa);
            chk(e_tag, "wd_sel",  int'(wd_sel),  e_wd);
            chk(e_tag, "pc_sel",  int'(pc_sel),  e_pc);
            chk(e_tag, "illegal", int'(illegal), e_il);
            // R10: strobes only for their own opcode, regardless of ra_zero
            chk("R10", "mem_we|rd2_sel only store",
                int'(mem_we | rd2_sel), (instr[31:26] == 6'b011001) ? 1 : 0);
            chk("R10", "a_sel only load-relative",
                int'(a_sel), (instr[31:26] == 6'b011111) ? 1 : 0);
        end
    end

    task automatic apply(input logic [31:0] w, input logic z);
        @(posedge clk);
        instr   = w;
        ra_zero = z;
    endtask

    initial begin
        logic [5:0] ops [7];
        ops = '{6'b100000, 6'b110000, 6'b011000, 6'b011001,
                6'b011011, 6'b011101, 6'b011111};
        rst_n   = 1'b0;
        instr   = 32'h0;
        ra_zero = 1'b0;
        // Reset state: opcode 0 is illegal (R9)
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Each supported instruction with several field and literal patterns
        for (int i = 0; i < 7; i++) begin
            for (int k = 0; k < 6; k++) begin
                logic [15:0] low;
                logic [4:0]  rc, ra;
                case (k)
                    0: low = 16'h0000;
                    1: low = 16'h7FFF;
                    2: low = 16'h8000;
                    3: low = 16'hFFFF;
                    4: low = 16'h1234;
                    default: low = 16'hA5C3;
                endcase
                rc = 5'(k * 7 + 3);
                ra = 5'(31 - k * 5);
                for (int z = 0; z < 2; z++)
                    apply({ops[i], rc, ra, low}, z[0]);
            end
        end
        // Branch-if-zero: alternate ra_zero back to back (R7)
        for (int n = 0; n < 8; n++)
            apply({6'b011101, 5'd4, 5'd9, 16'hFFFE}, n[0]);
        // Full opcode sweep with both zero values (R9, R10)
        for (int op = 0; op < 64; op++) begin
            apply({op[5:0], 5'd31, 5'd0, 16'h8001}, 1'b0);
            apply({op[5:0], 5'd0, 5'd31, 16'h7FFE}, 1'b1);
        end
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule